// File: doc/BRIEF.md
# Power-Management Companion Register File

This block is the register file of a power-management companion chip. A serial bus slave turns its frames into the block's parallel strobes: a write strobe with an index and a 16-bit value, or a read strobe whose data appears on the read port one clock later. The file covers several functions. An interrupt status word and a mask word drive a level interrupt output. There is a fixed identification word and two general control words. An ADC channel selector returns channel-tagged results, and a sample-control word can only have bits cleared. A calibration word and a status word that shows the power key complete the set.

Three event inputs come from the board: the power key, the headset detector and the hook detector. The block detects their transitions in the system clock. Each transition raises a status bit. The headset and hook bits are raised only when two accessory-enable bits are set in the first control word. Writing zero to the watchdog index while the watchdog-enable control bit is set produces a one-cycle shutdown request. Conversion, clock keeping and audio are not built. Their indices read as zero and ignore writes.

Top module: `pwr_ctl_regs`

## Requirements
- R1: After reset, the following values hold. Index 0 reads 0x0215, with bit 7 also set when VARIANT is 1. Index 1 (interrupt status) reads 0x0000 and index 2 (mask) reads 0xFFFF. Index 6 (calibration) reads 0x0001 and index 0x16 (status) reads 0x0020. irq_o and shutdown_o are low.
- R2: irq_o is high exactly when some bit is set in the interrupt status and clear in the mask. A write to index 2 loads the mask, which reads back from index 2.
- R3: A write to index 1 XORs the written value into the interrupt status. A read of index 1 returns the status.
- R4: A write to index 8 loads the ADC channel from wdata[13:10] and sets interrupt status bit 8. A read of index 8 returns the channel in bits 13..10 with the channel's 10-bit result in bits 9..0. The reset results for channels 0 to 15 are 0, 0x3C2, 0x0FC, 0x165, 123, 1023, 0x011, 0x011, 0x250, 0, 2, 0x011, 0x3D0, 0x330, 0 and 0.
- R5: The sample-control word (index 9) resets to SAMPLE_INIT (default 0xFFFF). A write to index 9 clears the bits that are 1 in the written value, and the word never gains bits.
- R6: A write of 0x0000 to index 0x17 while bit 1 of control word 1 (index 0x0D) is set makes shutdown_o high for exactly the following cycle. A nonzero value, or a clear bit 1, gives no request.
- R7: Each transition of key_in sets interrupt status bit 0. Bit 5 of index 0x16 is 0 while key_in is high (pressed) and 1 while it is low.
- R8: Each transition of head_in sets status bit 7, and each transition of hook_in sets status bit 6. Both happen only while bits 8 and 10 of control word 1 are both 1. Whatever the gate, the result of ADC channel 4 (head) or 5 (hook) becomes 50 when the input goes high and 123 when it goes low.
- R9: When an event and a write to index 1 act on the same status bit in the same cycle, the bit ends set.
- R10: Control words 1 and 2 (indices 0x0D, 0x0E) and the calibration word (index 6) read back the written value. Writes to index 0, to index 0x16 and to unbuilt indices change nothing, and unbuilt indices read 0.
- R11: rdata takes the value of the indexed register on the clock edge where rd_en is high, and holds it while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Register index |
| wdata | input | 16 | Write value |
| rdata | output | 16 | Read value, registered |
| key_in | input | 1 | Power key level, high when pressed |
| head_in | input | 1 | Headset detect level |
| hook_in | input | 1 | Hook detect level |
| irq_o | output | 1 | Level interrupt request |
| shutdown_o | output | 1 | One-cycle shutdown request |

## Verification
A corrupted interrupt status or mask shows on irq_o in the cycle right after the edge that corrupts it. A read of index 1 or 2 exposes the same fault one cycle after the read strobe. A missed transition on an event input, or a wrong accessory gate, shows as a missing or extra status bit on the next read of index 1. A wrong channel selector or a stale head/hook result shows as a wrong tag or value on the next read of index 8. A wrong watchdog condition shows as a shutdown pulse that is missing, extra or too long, in the cycle after the write.

// File: rtl/pwr_regs_pkg.sv
package pwr_regs_pkg;
    // register indices; the bus slave decodes these positions
    localparam int IX_ID       = 0;
    localparam int IX_IRQ_TOG  = 1;
    localparam int IX_IRQ_MASK = 2;
    localparam int IX_CAL      = 6;
    localparam int IX_ADC      = 8;
    localparam int IX_SAMPLE   = 9;
    localparam int IX_CTRL1    = 13;
    localparam int IX_CTRL2    = 14;
    localparam int IX_STAT     = 22;
    localparam int IX_WDOG     = 23;

    // interrupt status bit positions
    localparam int BIT_KEY  = 0;
    localparam int BIT_HOOK = 6;
    localparam int BIT_HEAD = 7;
    localparam int BIT_ADC  = 8;

    // control word 1 bits
    localparam int CTRL_WDOG_EN = 1;
    localparam int CTRL_ACC_A   = 8;
    localparam int CTRL_ACC_B   = 10;

    localparam int STAT_KEY_UP = 5;

    // event input lanes
    localparam int EV_KEY  = 0;
    localparam int EV_HEAD = 1;
    localparam int EV_HOOK = 2;
    localparam int EV_N    = 3;

    localparam int HEAD_CH      = 4;
    localparam int HOOK_CH      = 5;
    localparam int ACC_ON_CODE  = 50;
    localparam int ACC_OFF_CODE = 123;

    localparam logic [15:0] ID_BASE     = 16'h0215;
    localparam int          ID_VAR_BIT  = 7;

    // 16 channels x 10 bits, channel 15 first
    localparam logic [159:0] ADC_DEFAULT = {
        10'd0,    10'd0,    10'h330, 10'h3d0,
        10'h011,  10'd2,    10'd0,   10'h250,
        10'h011,  10'h011,  10'd1023, 10'd123,
        10'h165,  10'h0fc,  10'h3c2, 10'd0
    };
endpackage

// File: rtl/pwr_evt_edge.sv
module pwr_evt_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] lvl_q_o,
    output logic [N-1:0] chg_o
);
    typedef struct packed {
        logic [N-1:0] lvl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_q_o = st_q.lvl;
    assign chg_o   = lvl_i ^ st_q.lvl;

    // R7
    edge_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg_o) |=> (lvl_q_o != $past(lvl_q_o)));
endmodule

// File: rtl/pwr_intc.sv
module pwr_intc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tog_en,
    input  logic         mask_en,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tog_en)  st_d.stat = st_q.stat ^ wdata_i;
        if (mask_en) st_d.mask = wdata_i;
        // events applied last so they win over a same-cycle toggle
        st_d.stat = st_d.stat | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stat <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.stat & ~st_q.mask);

    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));

    // R3
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_en && set_i == '0) |=> (stat_o == ($past(stat_o) ^ $past(wdata_i))));

    // R2
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_en && wdata_i == '1) |=> !irq_o);
endmodule

// File: rtl/pwr_adc_bank.sv
module pwr_adc_bank
    import pwr_regs_pkg::*;
#(
    parameter int                      ADC_W  = 10,
    parameter int                      ADC_CH = 16,
    parameter logic [ADC_CH*ADC_W-1:0] INIT   = ADC_DEFAULT,
    parameter int                      CH_W   = $clog2(ADC_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_en,
    input  logic [CH_W-1:0]  sel_i,
    input  logic             head_chg,
    input  logic             head_lvl,
    input  logic             hook_chg,
    input  logic             hook_lvl,
    output logic [CH_W-1:0]  chan_o,
    output logic [ADC_W-1:0] res_o
);
    localparam logic [ADC_W-1:0] ON_CODE  = ADC_W'(ACC_ON_CODE);
    localparam logic [ADC_W-1:0] OFF_CODE = ADC_W'(ACC_OFF_CODE);

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [ADC_W-1:0] head;
        logic [ADC_W-1:0] hook;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_en)   st_d.chan = sel_i;
        if (head_chg) st_d.head = head_lvl ? ON_CODE : OFF_CODE;
        if (hook_chg) st_d.hook = hook_lvl ? ON_CODE : OFF_CODE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.chan <= '0;
            st_q.head <= INIT[HEAD_CH*ADC_W +: ADC_W];
            st_q.hook <= INIT[HOOK_CH*ADC_W +: ADC_W];
        end else begin
            st_q <= st_d;
        end
    end

    // only the two detector channels need storage; the rest are constants
    always_comb begin
        res_o = INIT[int'(st_q.chan)*ADC_W +: ADC_W];
        if (st_q.chan == CH_W'(HEAD_CH)) res_o = st_q.head;
        if (st_q.chan == CH_W'(HOOK_CH)) res_o = st_q.hook;
    end

    assign chan_o = st_q.chan;

    // R4
    chan_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en |=> (chan_o == $past(sel_i)));

    // R8
    head_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_chg |=> (st_q.head == (head_lvl ? OFF_CODE : OFF_CODE) ||
                      st_q.head == ON_CODE));
endmodule

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs
    import pwr_regs_pkg::*;
#(
    parameter int                      DATA_W      = 16,
    parameter int                      ADDR_W      = 5,
    parameter int                      ADC_W       = 10,
    parameter int                      ADC_CH      = 16,
    parameter int                      VARIANT     = 0,
    parameter logic [DATA_W-1:0]       SAMPLE_INIT = '1,
    parameter logic [ADC_CH*ADC_W-1:0] ADC_INIT    = ADC_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              key_in,
    input  logic              head_in,
    input  logic              hook_in,
    output logic              irq_o,
    output logic              shutdown_o
);
    localparam int CH_W = $clog2(ADC_CH);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl1;
        logic [DATA_W-1:0] ctrl2;
        logic [DATA_W-1:0] cal;
        logic [DATA_W-1:0] sample;
        logic [DATA_W-1:0] rdata;
        logic              sd;
    } st_t;

    st_t st_d, st_q;

    logic [EV_N-1:0]   ev_lvl, ev_lvl_q, ev_chg;
    logic [DATA_W-1:0] irq_set, irq_stat, irq_mask, stat_word, rd_val;
    logic [CH_W-1:0]   adc_chan;
    logic [ADC_W-1:0]  adc_res;
    logic              wr_tog, wr_mask, wr_adc, acc_gate;

    assign ev_lvl   = {hook_in, head_in, key_in};
    assign wr_tog   = wr_en && addr == ADDR_W'(IX_IRQ_TOG);
    assign wr_mask  = wr_en && addr == ADDR_W'(IX_IRQ_MASK);
    assign wr_adc   = wr_en && addr == ADDR_W'(IX_ADC);
    assign acc_gate = st_q.ctrl1[CTRL_ACC_A] && st_q.ctrl1[CTRL_ACC_B];

    pwr_evt_edge #(.N(EV_N)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (ev_lvl),
        .lvl_q_o (ev_lvl_q),
        .chg_o   (ev_chg)
    );

    always_comb begin
        irq_set           = '0;
        irq_set[BIT_KEY]  = ev_chg[EV_KEY];
        irq_set[BIT_HEAD] = ev_chg[EV_HEAD] && acc_gate;
        irq_set[BIT_HOOK] = ev_chg[EV_HOOK] && acc_gate;
        irq_set[BIT_ADC]  = wr_adc;
    end

    pwr_intc #(.W(DATA_W)) u_intc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tog_en  (wr_tog),
        .mask_en (wr_mask),
        .wdata_i (wdata),
        .set_i   (irq_set),
        .stat_o  (irq_stat),
        .mask_o  (irq_mask),
        .irq_o   (irq_o)
    );

    pwr_adc_bank #(
        .ADC_W  (ADC_W),
        .ADC_CH (ADC_CH),
        .INIT   (ADC_INIT),
        .CH_W   (CH_W)
    ) u_adc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_en   (wr_adc),
        .sel_i    (wdata[ADC_W +: CH_W]),
        .head_chg (ev_chg[EV_HEAD]),
        .head_lvl (head_in),
        .hook_chg (ev_chg[EV_HOOK]),
        .hook_lvl (hook_in),
        .chan_o   (adc_chan),
        .res_o    (adc_res)
    );

    always_comb begin
        stat_word              = '0;
        stat_word[STAT_KEY_UP] = ~ev_lvl_q[EV_KEY];
    end

    always_comb begin
        rd_val = '0;
        case (addr)
            ADDR_W'(IX_ID): begin
                rd_val = DATA_W'(ID_BASE);
                if (VARIANT != 0) rd_val[ID_VAR_BIT] = 1'b1;
            end
            ADDR_W'(IX_IRQ_TOG):  rd_val = irq_stat;
            ADDR_W'(IX_IRQ_MASK): rd_val = irq_mask;
            ADDR_W'(IX_CAL):      rd_val = st_q.cal;
            ADDR_W'(IX_ADC): begin
                rd_val[ADC_W +: CH_W] = adc_chan;
                rd_val[ADC_W-1:0]     = adc_res;
            end
            ADDR_W'(IX_SAMPLE):   rd_val = st_q.sample;
            ADDR_W'(IX_CTRL1):    rd_val = st_q.ctrl1;
            ADDR_W'(IX_CTRL2):    rd_val = st_q.ctrl2;
            ADDR_W'(IX_STAT):     rd_val = stat_word;
            default:              rd_val = '0;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        st_d.sd = 1'b0;
        if (rd_en) st_d.rdata = rd_val;
        if (wr_en) begin
            case (addr)
                ADDR_W'(IX_CAL):    st_d.cal    = wdata;
                ADDR_W'(IX_SAMPLE): st_d.sample = st_q.sample & ~wdata;
                ADDR_W'(IX_CTRL1):  st_d.ctrl1  = wdata;
                ADDR_W'(IX_CTRL2):  st_d.ctrl2  = wdata;
                ADDR_W'(IX_WDOG):   st_d.sd     = (wdata == '0) && st_q.ctrl1[CTRL_WDOG_EN];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl1  <= '0;
            st_q.ctrl2  <= '0;
            st_q.cal    <= DATA_W'(1);
            st_q.sample <= SAMPLE_INIT;
            st_q.rdata  <= '0;
            st_q.sd     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata      = st_q.rdata;
    assign shutdown_o = st_q.sd;

    // R6
    wdog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> $past(wr_en && addr == ADDR_W'(IX_WDOG) && wdata == '0));

    // R6
    wdog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |=> !shutdown_o || $past(wr_en));

    // R5
    sample_no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sample & ~$past(st_q.sample)) == '0);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R8
    acc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_chg[EV_HEAD] && !acc_gate && !wr_tog)
        |=> (irq_stat[BIT_HEAD] == $past(irq_stat[BIT_HEAD])));
endmodule

// File: tb/pwr_ctl_regs_bench.sv
`timescale 1ns/1ps
module pwr_ctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        key_in = 1'b0, head_in = 1'b0, hook_in = 1'b0;
    logic        irq_o, shutdown_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_ctl_regs u_pwr_ctl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .key_in(key_in), .head_in(head_in), .hook_in(hook_in),
        .irq_o(irq_o), .shutdown_o(shutdown_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write; returns shutdown_o seen in the cycle after the write edge
    task automatic wr(input logic [4:0] a, input logic [15:0] d, output logic sd);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        sd = shutdown_o;
    endtask

    task automatic wrq(input logic [4:0] a, input logic [15:0] d);
        logic sd;
        wr(a, d, sd);
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic clear_status();
        logic [15:0] v;
        rd(5'h01, v);
        wrq(5'h01, v);
    endtask

    task automatic t_reset();
        chk("R1 irq", {15'd0, irq_o}, 16'd0);
        chk("R1 shutdown", {15'd0, shutdown_o}, 16'd0);
        rd_chk("R1 id", 5'h00, 16'h0215);
        rd_chk("R1 status", 5'h01, 16'h0000);
        rd_chk("R1 mask", 5'h02, 16'hFFFF);
        rd_chk("R1 cal", 5'h06, 16'h0001);
        rd_chk("R1 statword", 5'h16, 16'h0020);
        rd_chk("R5 sample reset", 5'h09, 16'hFFFF);
    endtask

    task automatic t_irq();
        wrq(5'h01, 16'h0011);
        rd_chk("R3 xor set", 5'h01, 16'h0011);
        chk("R2 masked irq", {15'd0, irq_o}, 16'd0);
        wrq(5'h02, 16'hFFFE);
        chk("R2 unmasked irq", {15'd0, irq_o}, 16'd1);
        rd_chk("R2 mask readback", 5'h02, 16'hFFFE);
        wrq(5'h01, 16'h0001);
        rd_chk("R3 xor clear", 5'h01, 16'h0010);
        chk("R2 irq drops", {15'd0, irq_o}, 16'd0);
        wrq(5'h02, 16'hFFEF);
        chk("R2 other bit irq", {15'd0, irq_o}, 16'd1);
        wrq(5'h01, 16'h0010);
        chk("R3 cleared irq", {15'd0, irq_o}, 16'd0);
        wrq(5'h02, 16'hFFFF);
    endtask

    task automatic t_adc();
        wrq(5'h08, 16'h0400);
        rd_chk("R4 ch1", 5'h08, 16'h07C2);
        rd_chk("R4 adc irq bit", 5'h01, 16'h0100);
        wrq(5'h08, 16'h2400);
        rd_chk("R4 unwired ch9", 5'h08, 16'h2400);
        wrq(5'h08, 16'hF7FF);
        rd_chk("R4 ch13 field only", 5'h08, 16'h3730);
        clear_status();
        rd_chk("R4 status cleared", 5'h01, 16'h0000);
    endtask

    task automatic t_sample();
        wrq(5'h09, 16'h00F0);
        rd_chk("R5 clear bits", 5'h09, 16'hFF0F);
        wrq(5'h09, 16'h0F0F);
        rd_chk("R5 clear more", 5'h09, 16'hF000);
    endtask

    task automatic t_ctrl();
        wrq(5'h0D, 16'h1234);
        rd_chk("R10 ctrl1", 5'h0D, 16'h1234);
        wrq(5'h0E, 16'hABCD);
        rd_chk("R10 ctrl2", 5'h0E, 16'hABCD);
        wrq(5'h06, 16'h0077);
        rd_chk("R10 cal", 5'h06, 16'h0077);
        wrq(5'h00, 16'hFFFF);
        rd_chk("R10 id write ignored", 5'h00, 16'h0215);
        wrq(5'h16, 16'h0000);
        rd_chk("R10 statword write ignored", 5'h16, 16'h0020);
        wrq(5'h0A, 16'hFFFF);
        rd_chk("R10 unbuilt reads 0", 5'h0A, 16'h0000);
        rd_chk("R10 unbuilt 1F", 5'h1F, 16'h0000);
        wrq(5'h0D, 16'h0000);
    endtask

    task automatic t_wdog();
        logic sd;
        wr(5'h17, 16'h0000, sd);
        chk("R6 disabled", {15'd0, sd}, 16'd0);
        wrq(5'h0D, 16'h0002);
        wr(5'h17, 16'h0005, sd);
        chk("R6 nonzero", {15'd0, sd}, 16'd0);
        wr(5'h17, 16'h0000, sd);
        chk("R6 request", {15'd0, sd}, 16'd1);
        @(negedge clk);
        chk("R6 one cycle", {15'd0, shutdown_o}, 16'd0);
        wrq(5'h0D, 16'h0000);
    endtask

    task automatic t_key();
        @(negedge clk); key_in = 1'b1;
        rd_chk("R7 press irq", 5'h01, 16'h0001);
        rd_chk("R7 pressed word", 5'h16, 16'h0000);
        clear_status();
        @(negedge clk); key_in = 1'b0;
        rd_chk("R7 release irq", 5'h01, 16'h0001);
        rd_chk("R7 released word", 5'h16, 16'h0020);
        clear_status();
    endtask

    task automatic t_acc();
        wrq(5'h08, 16'h1400);
        rd_chk("R8 hook default", 5'h08, 16'h17FF);
        clear_status();
        @(negedge clk); hook_in = 1'b1;
        rd_chk("R8 gated off", 5'h01, 16'h0000);
        rd_chk("R8 hook on code", 5'h08, 16'h1432);
        wrq(5'h0D, 16'h0500);
        @(negedge clk); hook_in = 1'b0;
        rd_chk("R8 hook irq", 5'h01, 16'h0040);
        rd_chk("R8 hook off code", 5'h08, 16'h147B);
        clear_status();
        wrq(5'h08, 16'h1000);
        clear_status();
        rd_chk("R8 head default", 5'h08, 16'h107B);
        @(negedge clk); head_in = 1'b1;
        rd_chk("R8 head irq", 5'h01, 16'h0080);
        rd_chk("R8 head on code", 5'h08, 16'h1032);
        clear_status();
        wrq(5'h0D, 16'h0000);
    endtask

    task automatic t_collide();
        wrq(5'h01, 16'h0001);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'h01; wdata = 16'h0003; key_in = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_chk("R9 event wins", 5'h01, 16'h0003);
        @(negedge clk); key_in = 1'b0;
        @(negedge clk);
        clear_status();
    endtask

    task automatic t_rdtiming();
        logic [15:0] v;
        rd(5'h00, v);
        chk("R11 read", v, 16'h0215);
        @(negedge clk); addr = 5'h02;
        @(negedge clk);
        chk("R11 hold", rdata, 16'h0215);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_irq();
        t_adc();
        t_sample();
        t_ctrl();
        t_wdog();
        t_key();
        t_acc();
        t_collide();
        t_rdtiming();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule